// File: doc/BRIEF.md
# Adaptive Slope Delta Modulation Codec

This block turns a stream of signed, already digitized samples into a one-bit-per-period code and turns that code back into samples. On the encoding side, every accepted sample is compared with an internal tracking value. The result of that comparison is the emitted bit, and it moves the tracking value one step up or one step down. The decoding side receives the bit stream and runs an identical tracking loop, so its output sample follows the encoder's tracking value exactly.

The step is not fixed. A short window holds the most recent bits. While every bit in that window agrees, the loop is behind a fast-moving input, so the step grows geometrically on each period. Once the window holds a mix of ones and zeros, the step leaks back towards its floor. A strobe marks each bit period on the encoding side. The decoder advances on each valid received bit, so the bit output can drive the bit input directly.

The window length, the widths and the step limits are parameters. A generate option can also freeze the step at its floor, which gives plain delta modulation.

Top module: `cvsd_codec`

## Requirements
- R1: A sample is taken on a clock edge where both `ce` and `smp_valid` are high. At the next edge `bit_out` holds 1 if the sample is strictly greater than the tracking value and 0 otherwise, and `bit_valid` is high for exactly that one cycle.
- R2: A taken sample with bit 1 raises the tracking value (`enc_track`) by the current step, and bit 0 lowers it by the same step. The new value appears together with the bit.
- R3: The tracking value saturates at the signed limits of `W` bits (+32767 and -32768 by default) and never wraps.
- R4: After reset, `enc_track`, `rec_out`, `bit_out`, `bit_valid` and `rec_valid` are 0. The step is `STEP_MIN` (16 by default). The bit window holds the alternating pattern 0101 (newest bit at the right), so the first step is not a growth step.
- R5: The step always stays within `STEP_MIN` to `STEP_MAX` (16 to 2047 by default).
- R6: If the four bits in the window are all ones or all zeros when a bit is produced, the step used for the next bit becomes step + floor(step/8) + `STEP_MIN`, clipped to `STEP_MAX`.
- R7: If the window holds both values, the next step becomes step - floor(step/16), but never less than `STEP_MIN`.
- R8: On a cycle where `ce` or `smp_valid` is low, the tracking value and the step are left unchanged and `bit_valid` stays low.
- R9: Each cycle with `rx_valid` high feeds `rx_bit` into a copy of the same window, step rule and saturating accumulator. At the next edge `rec_out` holds the new value and `rec_valid` pulses. When `bit_out` and `bit_valid` are looped back, `rec_out` equals the encoder's tracking value bit for bit.
- R10: For a constant input held long enough, the bits alternate 1,0,1,0 and the tracking value stays within one step of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Bit-period strobe for the encoder |
| smp_valid | input | 1 | Sample input is valid |
| smp_in | input | W | Signed input sample |
| bit_out | output | 1 | Encoded bit, registered |
| bit_valid | output | 1 | One-cycle pulse with each new bit |
| enc_track | output | W | Encoder tracking value |
| rx_valid | input | 1 | Received bit is valid |
| rx_bit | input | 1 | Received bit |
| rec_out | output | W | Reconstructed signed sample |
| rec_valid | output | 1 | One-cycle pulse with each new reconstructed sample |

## Verification
The assertions assume that `smp_in` stays stable only while it is being sampled. They also assume that the decoder is fed the encoder's own bits, so the encoder and decoder loops begin from the same reset state. The stimulus drives all inputs on the falling edge and loops `bit_out`/`bit_valid` straight into `rx_bit`/`rx_valid`. It only releases reset on a falling edge, so both loops leave reset in the same cycle and stay aligned. The input patterns are a held zero, a large step, a sine, both full-scale rails, and strobe gaps where one of `ce` or `smp_valid` is low. Together these drive the step through growth, decay, the ceiling and the floor.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;
   localparam int unsigned CVSD_W_DEF        = 16;
   localparam int unsigned CVSD_SW_DEF       = 12;
   localparam int unsigned CVSD_STEP_MIN_DEF = 16;
   localparam int unsigned CVSD_STEP_MAX_DEF = 2047;
   localparam int unsigned CVSD_HIST_DEF     = 4;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } cvsd_dir_e;
endpackage

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt #(
   parameter int unsigned SW       = cvsd_pkg::CVSD_SW_DEF,
   parameter int unsigned STEP_MIN = cvsd_pkg::CVSD_STEP_MIN_DEF,
   parameter int unsigned STEP_MAX = cvsd_pkg::CVSD_STEP_MAX_DEF,
   parameter int unsigned HIST_LEN = cvsd_pkg::CVSD_HIST_DEF,
   parameter bit          ADAPT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic          bit_in,
   output logic [SW-1:0] step_o
);
   localparam int unsigned XW = SW + 2;
   localparam logic [SW-1:0] S_MIN = SW'(STEP_MIN);
   localparam logic [XW-1:0] S_MAX_X = XW'(STEP_MAX);
   localparam logic [XW-1:0] S_MIN_X = XW'(STEP_MIN);

   if (STEP_MIN < 1)              begin : g_chk_min  $error("STEP_MIN must be at least 1"); end
   if (STEP_MAX < STEP_MIN)       begin : g_chk_max  $error("STEP_MAX below STEP_MIN"); end
   if (STEP_MAX >= (1 << SW))     begin : g_chk_sw   $error("STEP_MAX does not fit SW"); end
   if (HIST_LEN < 2 || (HIST_LEN % 2) != 0) begin : g_chk_h $error("HIST_LEN must be even and >= 2"); end

   logic [SW-1:0] step_q;
   assign step_o = step_q;

   if (ADAPT_EN) begin : g_adaptive
      logic [HIST_LEN-1:0] hist_q;
      logic [HIST_LEN-2:0] diff;
      logic                run_flag;
      logic [XW-1:0]       grow;
      logic [SW-1:0]       decay;
      logic [SW-1:0]       step_nxt;

      for (genvar g = 0; g < HIST_LEN - 1; g++) begin : g_diff
         assign diff[g] = hist_q[g] ^ hist_q[g+1];
      end
      assign run_flag = ~|diff;

      always_comb begin
         grow  = XW'(step_q) + XW'(step_q >> 3) + S_MIN_X;
         decay = step_q - (step_q >> 4);
         if (run_flag) begin
            step_nxt = (grow > S_MAX_X) ? S_MAX_X[SW-1:0] : grow[SW-1:0];
         end else begin
            step_nxt = (decay < S_MIN) ? S_MIN : decay;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_q <= {(HIST_LEN/2){2'b01}};
            step_q <= S_MIN;
         end else if (upd) begin
            hist_q <= {hist_q[HIST_LEN-2:0], bit_in};
            step_q <= step_nxt;
         end
      end
   end else begin : g_fixed
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) step_q <= S_MIN;
         else        step_q <= S_MIN;
      end
   end
endmodule

// File: rtl/cvsd_accum.sv
module cvsd_accum #(
   parameter int unsigned W  = cvsd_pkg::CVSD_W_DEF,
   parameter int unsigned SW = cvsd_pkg::CVSD_SW_DEF
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd,
   input  cvsd_pkg::cvsd_dir_e dir,
   input  logic [SW-1:0]       step,
   output logic signed [W-1:0] acc_o
);
   if (SW >= W) begin : g_chk_w $error("SW must be narrower than W"); end

   localparam logic signed [W:0]   HI_X   = {2'b00, {(W-1){1'b1}}};
   localparam logic signed [W:0]   LO_X   = {2'b11, {(W-1){1'b0}}};
   localparam logic signed [W-1:0] HI_SAT = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] LO_SAT = {1'b1, {(W-1){1'b0}}};

   logic signed [W-1:0] acc_q;
   logic signed [W:0]   acc_x, step_x, sum_x;
   logic signed [W-1:0] acc_nxt;

   assign acc_x  = {acc_q[W-1], acc_q};
   assign step_x = $signed({{(W+1-SW){1'b0}}, step});

   always_comb begin
      if (dir == cvsd_pkg::DIR_UP) sum_x = acc_x + step_x;
      else                         sum_x = acc_x - step_x;
      if (sum_x > HI_X)      acc_nxt = HI_SAT;
      else if (sum_x < LO_X) acc_nxt = LO_SAT;
      else                   acc_nxt = sum_x[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (upd) acc_q <= acc_nxt;
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/cvsd_encoder.sv
module cvsd_encoder #(
   parameter int unsigned W        = cvsd_pkg::CVSD_W_DEF,
   parameter int unsigned SW       = cvsd_pkg::CVSD_SW_DEF,
   parameter int unsigned STEP_MIN = cvsd_pkg::CVSD_STEP_MIN_DEF,
   parameter int unsigned STEP_MAX = cvsd_pkg::CVSD_STEP_MAX_DEF,
   parameter int unsigned HIST_LEN = cvsd_pkg::CVSD_HIST_DEF,
   parameter bit          ADAPT_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic signed [W-1:0] smp,
   output logic                bit_o,
   output logic                vld_o,
   output logic signed [W-1:0] track_o,
   output logic [SW-1:0]       step_o
);
   logic                cmp;
   cvsd_pkg::cvsd_dir_e dir;

   assign cmp = (smp > track_o);
   assign dir = cmp ? cvsd_pkg::DIR_UP : cvsd_pkg::DIR_DOWN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_o <= 1'b0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= take;
         if (take) bit_o <= cmp;
      end
   end

   cvsd_step_adapt #(.SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
                     .HIST_LEN(HIST_LEN), .ADAPT_EN(ADAPT_EN)) u_adapt (
      .clk(clk), .rst_n(rst_n), .upd(take), .bit_in(cmp), .step_o(step_o));

   cvsd_accum #(.W(W), .SW(SW)) u_acc (
      .clk(clk), .rst_n(rst_n), .upd(take), .dir(dir), .step(step_o), .acc_o(track_o));
endmodule

// File: rtl/cvsd_decoder.sv
module cvsd_decoder #(
   parameter int unsigned W        = cvsd_pkg::CVSD_W_DEF,
   parameter int unsigned SW       = cvsd_pkg::CVSD_SW_DEF,
   parameter int unsigned STEP_MIN = cvsd_pkg::CVSD_STEP_MIN_DEF,
   parameter int unsigned STEP_MAX = cvsd_pkg::CVSD_STEP_MAX_DEF,
   parameter int unsigned HIST_LEN = cvsd_pkg::CVSD_HIST_DEF,
   parameter bit          ADAPT_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld_i,
   input  logic                bit_i,
   output logic signed [W-1:0] smp_o,
   output logic                vld_o
);
   logic [SW-1:0]       step;
   cvsd_pkg::cvsd_dir_e dir;

   assign dir = bit_i ? cvsd_pkg::DIR_UP : cvsd_pkg::DIR_DOWN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= vld_i;
   end

   cvsd_step_adapt #(.SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
                     .HIST_LEN(HIST_LEN), .ADAPT_EN(ADAPT_EN)) u_adapt (
      .clk(clk), .rst_n(rst_n), .upd(vld_i), .bit_in(bit_i), .step_o(step));

   cvsd_accum #(.W(W), .SW(SW)) u_acc (
      .clk(clk), .rst_n(rst_n), .upd(vld_i), .dir(dir), .step(step), .acc_o(smp_o));
endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec #(
   parameter int unsigned W        = cvsd_pkg::CVSD_W_DEF,
   parameter int unsigned SW       = cvsd_pkg::CVSD_SW_DEF,
   parameter int unsigned STEP_MIN = cvsd_pkg::CVSD_STEP_MIN_DEF,
   parameter int unsigned STEP_MAX = cvsd_pkg::CVSD_STEP_MAX_DEF,
   parameter int unsigned HIST_LEN = cvsd_pkg::CVSD_HIST_DEF,
   parameter bit          ADAPT_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce,
   input  logic                smp_valid,
   input  logic signed [W-1:0] smp_in,
   output logic                bit_out,
   output logic                bit_valid,
   output logic signed [W-1:0] enc_track,
   input  logic                rx_valid,
   input  logic                rx_bit,
   output logic signed [W-1:0] rec_out,
   output logic                rec_valid
);
   logic          enc_take;
   logic [SW-1:0] enc_step;

   assign enc_take = ce & smp_valid;

   cvsd_encoder #(.W(W), .SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
                  .HIST_LEN(HIST_LEN), .ADAPT_EN(ADAPT_EN)) u_enc (
      .clk(clk), .rst_n(rst_n), .take(enc_take), .smp(smp_in),
      .bit_o(bit_out), .vld_o(bit_valid), .track_o(enc_track), .step_o(enc_step));

   cvsd_decoder #(.W(W), .SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
                  .HIST_LEN(HIST_LEN), .ADAPT_EN(ADAPT_EN)) u_dec (
      .clk(clk), .rst_n(rst_n), .vld_i(rx_valid), .bit_i(rx_bit),
      .smp_o(rec_out), .vld_o(rec_valid));
endmodule

// File: rtl/cvsd_codec_chk.sv
module cvsd_codec_chk #(
   parameter int unsigned W        = 16,
   parameter int unsigned SW       = 12,
   parameter int unsigned STEP_MIN = 16,
   parameter int unsigned STEP_MAX = 2047
) (
   input logic                clk,
   input logic                rst_n,
   input logic                enc_take,
   input logic signed [W-1:0] smp_in,
   input logic                bit_out,
   input logic                bit_valid,
   input logic signed [W-1:0] enc_track,
   input logic [SW-1:0]       enc_step
);
   // R1: the bit follows a strict comparison of the sample against the tracking value
   p_bit_cmp_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_take && (smp_in > enc_track)) |=> (bit_valid && bit_out));

   // R2: the tracking value never moves against the emitted bit
   p_dir_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && bit_out) |-> (enc_track >= $past(enc_track)));
   p_dir_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !bit_out) |-> (enc_track <= $past(enc_track)));

   // R5: the step stays between its floor and its ceiling
   p_step_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_step >= SW'(STEP_MIN)) && (enc_step <= SW'(STEP_MAX)));

   // R8: without a taken sample, nothing in the loop moves
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enc_take |=> ($stable(enc_track) && $stable(enc_step) && !bit_valid));
endmodule

bind cvsd_codec cvsd_codec_chk #(.W(W), .SW(SW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .enc_take(enc_take), .smp_in(smp_in),
   .bit_out(bit_out), .bit_valid(bit_valid), .enc_track(enc_track), .enc_step(enc_step));

// File: tb/tb_cvsd_codec.sv
`timescale 1ns/1ps
module tb_cvsd_codec;
   localparam int SMIN = 16;
   localparam int SMAX = 2047;
   localparam int HI   = 32767;
   localparam int LO   = -32768;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b0, smp_valid = 1'b0;
   logic signed [15:0] smp_in = '0;
   logic bit_out, bit_valid, rec_valid;
   logic signed [15:0] enc_track, rec_out;

   int checks = 0, fails = 0;
   int m_acc = 0, m_step = SMIN;
   logic [3:0] m_hist = 4'b0101;
   int q_bit[$], q_enc[$], q_dec[$];
   logic [31:0] obs_bits = '0;
   int max_seen = 0, min_seen = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cvsd_codec dut (
      .clk(clk), .rst_n(rst_n), .ce(ce), .smp_valid(smp_valid), .smp_in(smp_in),
      .bit_out(bit_out), .bit_valid(bit_valid), .enc_track(enc_track),
      .rx_valid(bit_valid), .rx_bit(bit_out), .rec_out(rec_out), .rec_valid(rec_valid));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // reference loop built from R2, R3, R6, R7
   task automatic model_bit(input bit b);
      bit run = (m_hist == 4'hF) || (m_hist == 4'h0);
      int ns;
      m_acc = b ? m_acc + m_step : m_acc - m_step;
      if (m_acc > HI) m_acc = HI;
      if (m_acc < LO) m_acc = LO;
      if (run) begin
         ns = m_step + (m_step >> 3) + SMIN;
         if (ns > SMAX) ns = SMAX;
      end else begin
         ns = m_step - (m_step >> 4);
         if (ns < SMIN) ns = SMIN;
      end
      m_step = ns;
      m_hist = {m_hist[2:0], b};
   endtask

   task automatic drive(input int x);
      bit b;
      @(negedge clk);
      ce = 1'b1; smp_valid = 1'b1; smp_in = 16'(x);
      b = (x > m_acc);
      model_bit(b);
      q_bit.push_back(int'(b));
      q_enc.push_back(m_acc);
      q_dec.push_back(m_acc);
   endtask

   task automatic settle();
      @(negedge clk);
      ce = 1'b0; smp_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // monitor: pops the expected items as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (bit_valid) begin
            obs_bits = {obs_bits[30:0], bit_out};
            if (int'(enc_track) > max_seen) max_seen = int'(enc_track);
            if (int'(enc_track) < min_seen) min_seen = int'(enc_track);
            if (q_bit.size() == 0) check("R8 unexpected bit_valid", 1, 0);
            else begin
               check("R1 bit", int'(bit_out), q_bit.pop_front());
               check("R2 R3 R6 R7 enc_track", int'(enc_track), q_enc.pop_front());
            end
         end
         if (rec_valid) begin
            if (q_dec.size() == 0) check("R9 unexpected rec_valid", 1, 0);
            else check("R9 rec_out", int'(rec_out), q_dec.pop_front());
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int err;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reset state
      check("R4 enc_track", int'(enc_track), 0);
      check("R4 rec_out", int'(rec_out), 0);
      check("R4 bit_valid", int'(bit_valid), 0);
      check("R4 rec_valid", int'(rec_valid), 0);
      check("R4 bit_out", int'(bit_out), 0);

      // R10: held zero
      for (int i = 0; i < 40; i++) drive(0);
      settle();
      check("R10 zero alternation", int'(((obs_bits ^ (obs_bits >> 1)) & 32'h7FFF) == 32'h7FFF), 1);

      // R6 R7 R10: large step
      for (int i = 0; i < 300; i++) drive(8000);
      settle();
      err = int'(enc_track) - 8000;
      if (err < 0) err = -err;
      check("R10 step tracking error within one step", int'(err <= SMIN), 1);
      check("R10 step alternation", int'(((obs_bits ^ (obs_bits >> 1)) & 32'h7FFF) == 32'h7FFF), 1);

      // R2 R6 R7 R9: sine
      for (int i = 0; i < 256; i++) drive(int'(6000.0 * $sin(6.283185307 * i / 64.0)));
      settle();

      // R3: both rails
      for (int i = 0; i < 200; i++) drive(HI);
      settle();
      check("R3 upper saturation", max_seen, HI);
      for (int i = 0; i < 250; i++) drive(LO);
      settle();
      check("R3 lower saturation", min_seen, LO);
      check("R5 R7 model step at floor region", int'(m_step <= SMAX && m_step >= SMIN), 1);

      // R8: strobe gaps
      @(negedge clk);
      ce = 1'b0; smp_valid = 1'b1; smp_in = 16'sd20000;
      repeat (3) @(negedge clk);
      check("R8 ce low keeps track", int'(enc_track), m_acc);
      check("R8 ce low no bit_valid", int'(bit_valid), 0);
      ce = 1'b1; smp_valid = 1'b0;
      repeat (3) @(negedge clk);
      check("R8 valid low keeps track", int'(enc_track), m_acc);
      check("R8 valid low no rec_valid", int'(rec_valid), 0);
      for (int i = 0; i < 30; i++) drive(-1234);
      settle();
      check("R9 decoder equals encoder", int'(rec_out), int'(enc_track));
      check("R9 queues drained", q_enc.size() + q_dec.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule